// File: doc/BRIEF.md
# Host Command to Memory-Port Bridge

This block sits between a serial host link and the user port of a memory controller. The host hands over one 64-bit command word at a time. The word carries a one-bit opcode, a word address and a 32-bit data value. The bridge decodes the word, converts the word address into the byte address the port expects, and drives the port's three FIFO-style channels: command, write data and read data.

A write pushes the data word into the write-data FIFO and then issues a single-word write command. A read issues a single-word read command, waits for the read-data FIFO to hold a word, pops it, and returns it to the host with a one-cycle valid strobe. Only one command is in flight at any time. The host sees a busy flag while a command is being carried out.

Top module: `hostcmd_mport_bridge`

## Requirements
- R1: The host word is decoded as follows. Bit 63 is the opcode (0 = write, 1 = read). Bits 62..37 hold the 26-bit word address. Bits 31..0 hold the write data. Bits 36..32 are ignored.
- R2: The port instruction code is 3'b000 for a write and 3'b001 for a read.
- R3: The port command address is a 30-bit byte address equal to the word address shifted left by two. Its bits 1..0 are zero and its bits 29..28 are zero.
- R4: Every command has burst-length field 0 (one word). Every write-data push carries mask 4'b0000 (all four bytes written).
- R5: On a write, the data push happens in an earlier cycle than the write command enable.
- R6: No write-data push occurs while the write FIFO or the command FIFO reports full. No command enable occurs while the command FIFO reports full.
- R7: On a read, the bridge pops only when the read FIFO is non-empty and pops exactly one word. The cycle after the pop, it presents that word on the host read data with a valid pulse one cycle wide.
- R8: A host command presented while busy is ignored. It causes no port activity and no change to memory.
- R9: Busy rises in the cycle after acceptance. It stays high until the write command has been issued or the read word has been popped.
- R10: Command, write and read enables are single-cycle pulses. No command is issued while a read is outstanding.
- R11: Adjacent word addresses reach distinct storage. Data written to one word is read back unchanged and does not alter its neighbour.
- R12: After reset, busy, read valid and all three port enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host command word present |
| host_word | input | 64 | Packed host command word |
| host_busy | output | 1 | Command in progress; new words ignored |
| host_rd_valid | output | 1 | One-cycle strobe for returned read data |
| host_rd_data | output | 32 | Returned read data |
| mp_cmd_en | output | 1 | Command FIFO push |
| mp_cmd_instr | output | 3 | Instruction code |
| mp_cmd_bl | output | 6 | Burst length minus one |
| mp_cmd_addr | output | 30 | Byte address |
| mp_cmd_full | input | 1 | Command FIFO full |
| mp_wr_en | output | 1 | Write-data FIFO push |
| mp_wr_data | output | 32 | Write data |
| mp_wr_mask | output | 4 | Byte mask, 1 = byte suppressed |
| mp_wr_full | input | 1 | Write-data FIFO full |
| mp_rd_en | output | 1 | Read-data FIFO pop |
| mp_rd_data | input | 32 | Read-data FIFO head word |
| mp_rd_empty | input | 1 | Read-data FIFO empty |

## Verification
Distinct values are written to eight consecutive word addresses and read back. This separates a correct shift from an address that drops or folds its low bit, which would make neighbours share storage. A lone write to an odd address followed by reads of both neighbours shows whether even-address writes are lost. The all-ones word address checks the zero padding above the byte address. Full flags on each FIFO, varied read latency, and a command pushed while busy show the handshake ordering and that extra commands are dropped.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WR_PUSH = 3'd1,
    ST_WR_CMD  = 3'd2,
    ST_RD_CMD  = 3'd3,
    ST_RD_WAIT = 3'd4
  } hmb_state_t;

  localparam logic [2:0] INSTR_WRITE = 3'b000;
  localparam logic [2:0] INSTR_READ  = 3'b001;
endpackage

// File: rtl/hmb_decode.sv
module hmb_decode #(
  parameter int HOST_W  = 64,
  parameter int WADDR_W = 26,
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 30,
  parameter int INSTR_W = 3
) (
  input  logic [HOST_W-1:0]  word_i,
  output logic               is_read_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic [PADDR_W-1:0] byte_addr_o,
  output logic [DATA_W-1:0]  wdata_o
);
  localparam int OP_BIT   = HOST_W - 1;
  localparam int ADDR_LSB = OP_BIT - WADDR_W;
  localparam int BYTE_SH  = $clog2(DATA_W / 8);

  // word address to byte address: shift by byte lanes, zero padding above
  function automatic logic [PADDR_W-1:0] word_to_byte(input logic [WADDR_W-1:0] w);
    logic [PADDR_W-1:0] t;
    t = '0;
    t[BYTE_SH +: WADDR_W] = w;
    return t;
  endfunction

  // single opcode bit zero-extended into the instruction field
  function automatic logic [INSTR_W-1:0] op_to_instr(input logic op);
    logic [INSTR_W-1:0] t;
    t = '0;
    t[0] = op;
    return t;
  endfunction

  logic [WADDR_W-1:0] waddr;

  assign is_read_o   = word_i[OP_BIT];
  assign waddr       = word_i[ADDR_LSB +: WADDR_W];
  assign wdata_o     = word_i[DATA_W-1:0];
  assign instr_o     = op_to_instr(is_read_o);
  assign byte_addr_o = word_to_byte(waddr);

  generate
    if (ADDR_LSB > DATA_W) begin : g_pad
      logic unused_pad_bits;
      assign unused_pad_bits = ^word_i[ADDR_LSB-1:DATA_W];
    end
  endgenerate
endmodule

// File: rtl/hmb_seq.sv
module hmb_seq
  import hmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_valid_i,
  input  logic host_is_read_i,
  input  logic cmd_full_i,
  input  logic wr_full_i,
  input  logic rd_empty_i,
  output logic busy_o,
  output logic accept_o,
  output logic wr_push_o,
  output logic cmd_issue_o,
  output logic rd_pop_o
);
  hmb_state_t state_q, state_d;

  always_comb begin
    state_d     = state_q;
    accept_o    = 1'b0;
    wr_push_o   = 1'b0;
    cmd_issue_o = 1'b0;
    rd_pop_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        accept_o = host_valid_i;
        if (host_valid_i) state_d = host_is_read_i ? ST_RD_CMD : ST_WR_PUSH;
      end
      ST_WR_PUSH: begin
        wr_push_o = !wr_full_i && !cmd_full_i;
        if (wr_push_o) state_d = ST_WR_CMD;
      end
      ST_WR_CMD: begin
        cmd_issue_o = !cmd_full_i;
        if (cmd_issue_o) state_d = ST_IDLE;
      end
      ST_RD_CMD: begin
        cmd_issue_o = !cmd_full_i;
        if (cmd_issue_o) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        rd_pop_o = !rd_empty_i;
        if (rd_pop_o) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/hostcmd_mport_bridge.sv
module hostcmd_mport_bridge #(
  parameter int HOST_W  = 64,
  parameter int WADDR_W = 26,
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 30,
  parameter int INSTR_W = 3,
  parameter int BL_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic [HOST_W-1:0]  host_word,
  output logic               host_busy,
  output logic               host_rd_valid,
  output logic [DATA_W-1:0]  host_rd_data,
  output logic               mp_cmd_en,
  output logic [INSTR_W-1:0] mp_cmd_instr,
  output logic [BL_W-1:0]    mp_cmd_bl,
  output logic [PADDR_W-1:0] mp_cmd_addr,
  input  logic               mp_cmd_full,
  output logic               mp_wr_en,
  output logic [DATA_W-1:0]  mp_wr_data,
  output logic [DATA_W/8-1:0] mp_wr_mask,
  input  logic               mp_wr_full,
  output logic               mp_rd_en,
  input  logic [DATA_W-1:0]  mp_rd_data,
  input  logic               mp_rd_empty
);
  localparam int MASK_W = DATA_W / 8;

  // named internal events, observed by the bound checker
  logic accept_evt, wr_push_evt, cmd_issue_evt, rd_pop_evt;

  logic [HOST_W-1:0] cmd_word_q;
  logic              dec_is_read;
  logic              unused_dec_is_read;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  hmb_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_valid_i   (host_valid),
    .host_is_read_i (host_word[HOST_W-1]),
    .cmd_full_i     (mp_cmd_full),
    .wr_full_i      (mp_wr_full),
    .rd_empty_i     (mp_rd_empty),
    .busy_o         (host_busy),
    .accept_o       (accept_evt),
    .wr_push_o      (wr_push_evt),
    .cmd_issue_o    (cmd_issue_evt),
    .rd_pop_o       (rd_pop_evt)
  );

  hmb_decode #(
    .HOST_W  (HOST_W),
    .WADDR_W (WADDR_W),
    .DATA_W  (DATA_W),
    .PADDR_W (PADDR_W),
    .INSTR_W (INSTR_W)
  ) u_dec (
    .word_i      (cmd_word_q),
    .is_read_o   (dec_is_read),
    .instr_o     (mp_cmd_instr),
    .byte_addr_o (mp_cmd_addr),
    .wdata_o     (mp_wr_data)
  );

  assign unused_dec_is_read = dec_is_read;

  // command word held for the whole transaction
  always_ff @(posedge clk) begin
    if (!rst_n)          cmd_word_q <= '0;
    else if (accept_evt) cmd_word_q <= host_word;
  end

  // read return path: one registered stage after the pop
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_pop_evt;
      if (rd_pop_evt) rd_data_q <= mp_rd_data;
    end
  end

  assign mp_cmd_en     = cmd_issue_evt;
  assign mp_wr_en      = wr_push_evt;
  assign mp_rd_en      = rd_pop_evt;
  assign mp_cmd_bl     = '0;
  assign mp_wr_mask    = {MASK_W{1'b0}};
  assign host_rd_valid = rd_valid_q;
  assign host_rd_data  = rd_data_q;
endmodule

// File: rtl/hmb_checker.sv
module hmb_checker #(
  parameter int INSTR_W = 3,
  parameter int PADDR_W = 30,
  parameter int BL_W    = 6,
  parameter int MASK_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic               host_busy,
  input logic               host_rd_valid,
  input logic               accept_evt,
  input logic               mp_cmd_en,
  input logic [INSTR_W-1:0] mp_cmd_instr,
  input logic [BL_W-1:0]    mp_cmd_bl,
  input logic [PADDR_W-1:0] mp_cmd_addr,
  input logic               mp_cmd_full,
  input logic               mp_wr_en,
  input logic [MASK_W-1:0]  mp_wr_mask,
  input logic               mp_wr_full,
  input logic               mp_rd_en,
  input logic               mp_rd_empty
);
  logic is_wr_cmd, is_rd_cmd;
  logic wr_pending, rd_outstanding;

  assign is_wr_cmd = mp_cmd_en && (mp_cmd_instr == hmb_pkg::INSTR_WRITE);
  assign is_rd_cmd = mp_cmd_en && (mp_cmd_instr == hmb_pkg::INSTR_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_pending     <= 1'b0;
      rd_outstanding <= 1'b0;
    end else begin
      if (mp_wr_en)       wr_pending <= 1'b1;
      else if (is_wr_cmd) wr_pending <= 1'b0;
      if (is_rd_cmd)      rd_outstanding <= 1'b1;
      else if (mp_rd_en)  rd_outstanding <= 1'b0;
    end
  end

  p_instr_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mp_cmd_en |-> (is_wr_cmd || is_rd_cmd));
  p_addr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mp_cmd_en |-> (mp_cmd_addr[1:0] == 2'b00));
  p_single_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mp_cmd_en |-> (mp_cmd_bl == '0));
  p_full_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mp_wr_en |-> (mp_wr_mask == '0));
  p_push_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr_cmd |-> wr_pending);
  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mp_wr_en |-> (!mp_wr_full && !mp_cmd_full));
  p_no_cmd_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mp_cmd_en |-> !mp_cmd_full);
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mp_rd_en |-> (!mp_rd_empty && rd_outstanding));
  p_valid_after_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mp_rd_en |=> host_rd_valid);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_valid |=> !host_rd_valid);
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_busy) |-> !accept_evt);
  p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> host_busy);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && !is_wr_cmd && !mp_rd_en) |=> host_busy);
  p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mp_cmd_en |=> !mp_cmd_en);
  p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mp_wr_en |=> !mp_wr_en);
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mp_cmd_en |-> !rd_outstanding);
endmodule

bind hostcmd_mport_bridge hmb_checker #(
  .INSTR_W (INSTR_W),
  .PADDR_W (PADDR_W),
  .BL_W    (BL_W),
  .MASK_W  (DATA_W / 8)
) u_hmb_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_valid    (host_valid),
  .host_busy     (host_busy),
  .host_rd_valid (host_rd_valid),
  .accept_evt    (accept_evt),
  .mp_cmd_en     (mp_cmd_en),
  .mp_cmd_instr  (mp_cmd_instr),
  .mp_cmd_bl     (mp_cmd_bl),
  .mp_cmd_addr   (mp_cmd_addr),
  .mp_cmd_full   (mp_cmd_full),
  .mp_wr_en      (mp_wr_en),
  .mp_wr_mask    (mp_wr_mask),
  .mp_wr_full    (mp_wr_full),
  .mp_rd_en      (mp_rd_en),
  .mp_rd_empty   (mp_rd_empty)
);

// File: tb/hostcmd_mport_bridge_test.sv
`timescale 1ns/1ps
module hostcmd_mport_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic [63:0] host_word = '0;
  logic        host_busy, host_rd_valid;
  logic [31:0] host_rd_data;
  logic        mp_cmd_en, mp_wr_en, mp_rd_en;
  logic [2:0]  mp_cmd_instr;
  logic [5:0]  mp_cmd_bl;
  logic [29:0] mp_cmd_addr;
  logic [31:0] mp_wr_data;
  logic [3:0]  mp_wr_mask;
  logic        mp_cmd_full = 1'b0;
  logic        mp_wr_full = 1'b0;
  logic [31:0] mp_rd_data = '0;
  logic        mp_rd_empty = 1'b1;

  always #2.5 clk = ~clk;

  hostcmd_mport_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_word(host_word),
    .host_busy(host_busy), .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
    .mp_cmd_en(mp_cmd_en), .mp_cmd_instr(mp_cmd_instr), .mp_cmd_bl(mp_cmd_bl),
    .mp_cmd_addr(mp_cmd_addr), .mp_cmd_full(mp_cmd_full), .mp_wr_en(mp_wr_en),
    .mp_wr_data(mp_wr_data), .mp_wr_mask(mp_wr_mask), .mp_wr_full(mp_wr_full),
    .mp_rd_en(mp_rd_en), .mp_rd_data(mp_rd_data), .mp_rd_empty(mp_rd_empty)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cnt_cmd = 0, cnt_wr = 0, cnt_rd = 0, exp_cmds = 0;
  int rd_lat = 2;
  logic [29:0] exp_addr = '0;
  logic [2:0]  exp_instr = '0;
  logic [31:0] model_mem [logic [29:0]];
  logic [31:0] ref_mem   [logic [25:0]];
  logic [31:0] wr_q[$];
  logic [31:0] sb_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural port model: command, write-data and read-data channels
  int  lat_cnt = 0;
  int  prev_cmd = 0;
  bit  rd_out = 0;
  logic [31:0] pend_val;
  always @(posedge clk) begin
    if (rst_n) begin
      if (mp_cmd_en) begin
        cnt_cmd++;
        chk(prev_cmd == 0, "R10 cmd pulse", 1, 0);
        chk(!rd_out, "R10 outstanding read", 1, 0);
        chk(!mp_cmd_full, "R6 cmd while full", 1, 0);
        chk(mp_cmd_addr == exp_addr, "R3 byte address", mp_cmd_addr, exp_addr);
        chk(mp_cmd_instr == exp_instr, "R2 instruction", mp_cmd_instr, exp_instr);
        chk(mp_cmd_bl == 6'd0, "R4 burst length", mp_cmd_bl, 0);
        if (mp_cmd_instr == 3'b000) begin
          chk(wr_q.size() == 1, "R5 push before command", wr_q.size(), 1);
          if (wr_q.size() > 0) model_mem[mp_cmd_addr] = wr_q.pop_front();
        end else begin
          pend_val = model_mem.exists(mp_cmd_addr) ? model_mem[mp_cmd_addr] : 32'h0;
          lat_cnt  = rd_lat;
          rd_out   = 1;
        end
      end else if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          mp_rd_data  <= pend_val;
          mp_rd_empty <= 1'b0;
        end
      end
      prev_cmd = mp_cmd_en ? 1 : 0;
      if (mp_wr_en) begin
        cnt_wr++;
        chk(!mp_wr_full && !mp_cmd_full, "R6 push while full", 1, 0);
        chk(mp_wr_mask == 4'b0000, "R4 write mask", mp_wr_mask, 0);
        wr_q.push_back(mp_wr_data);
      end
      if (mp_rd_en) begin
        cnt_rd++;
        chk(!mp_rd_empty, "R7 pop while empty", 1, 0);
        mp_rd_empty <= 1'b1;
        rd_out = 0;
      end
    end
  end

  // scoreboard monitor
  bit prev_rv = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_rd_valid) begin
        chk(!prev_rv, "R7 valid pulse width", 1, 0);
        if (sb_q.size() == 0) chk(0, "R7 unexpected read data", host_rd_data, 0);
        else begin
          logic [31:0] e;
          e = sb_q.pop_front();
          chk(host_rd_data == e, "R11 R1 read data", host_rd_data, e);
        end
      end
      prev_rv = host_rd_valid;
    end
  end

  task automatic wait_idle();
    while (host_busy) @(negedge clk);
  endtask

  task automatic send(input bit rd, input logic [25:0] wa, input logic [31:0] d);
    wait_idle();
    exp_addr  = {2'b00, wa, 2'b00};
    exp_instr = {2'b00, rd};
    host_word = {rd, wa, 5'b10101, d};
    host_valid = 1'b1;
    exp_cmds++;
    if (rd) sb_q.push_back(ref_mem.exists(wa) ? ref_mem[wa] : 32'h0);
    else    ref_mem[wa] = d;
    @(negedge clk);
    host_valid = 1'b0;
    chk(host_busy, "R9 busy after accept", host_busy, 1);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!host_busy && !host_rd_valid, "R12 reset outputs", {host_busy, host_rd_valid}, 0);
    chk(!mp_cmd_en && !mp_wr_en && !mp_rd_en, "R12 reset enables", {mp_cmd_en, mp_wr_en, mp_rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: adjacent words distinct
    for (int i = 0; i < 8; i++) send(0, 26'(i), 32'hA500_0000 + 32'(i * 17 + 3));
    for (int i = 0; i < 8; i++) send(1, 26'(i), 0);
    // R11: lone odd-address write must not touch the even neighbour
    send(0, 26'd41, 32'h1111_2222);
    send(1, 26'd40, 0);
    send(1, 26'd41, 0);
    send(0, 26'd40, 32'h3333_4444);
    send(1, 26'd41, 0);
    send(1, 26'd40, 0);
    // R3: top word address, padding above
    send(0, 26'h3FF_FFFF, 32'hDEAD_BEEF);
    send(1, 26'h3FF_FFFF, 0);
    send(0, 26'h2AA_AAAA, 32'h0F0F_F0F0);
    send(1, 26'h2AA_AAAA, 0);

    // R6: command FIFO full stalls the write push
    wait_idle();
    mp_cmd_full = 1'b1;
    begin
      int c0, w0;
      c0 = cnt_cmd; w0 = cnt_wr;
      send(0, 26'd100, 32'hCAFE_0001);
      repeat (6) @(negedge clk);
      chk(cnt_cmd == c0 && cnt_wr == w0, "R6 stall on cmd full", cnt_cmd + cnt_wr, c0 + w0);
      chk(host_busy, "R9 busy during stall", host_busy, 1);
      mp_cmd_full = 1'b0;
      // R6: write FIFO full
      wait_idle();
      mp_wr_full = 1'b1;
      c0 = cnt_cmd; w0 = cnt_wr;
      send(0, 26'd101, 32'hCAFE_0002);
      repeat (6) @(negedge clk);
      chk(cnt_cmd == c0 && cnt_wr == w0, "R6 stall on wr full", cnt_cmd + cnt_wr, c0 + w0);
      mp_wr_full = 1'b0;
      // R6: read command held while cmd full
      wait_idle();
      mp_cmd_full = 1'b1;
      c0 = cnt_cmd;
      send(1, 26'd100, 0);
      repeat (5) @(negedge clk);
      chk(cnt_cmd == c0, "R6 read held on cmd full", cnt_cmd, c0);
      mp_cmd_full = 1'b0;
    end
    send(1, 26'd101, 0);

    // R7, R9: long read latency, busy held while waiting
    wait_idle();
    rd_lat = 9;
    send(1, 26'd3, 0);
    repeat (5) @(negedge clk);
    chk(host_busy && cnt_rd < exp_cmds, "R9 busy while read pending", host_busy, 1);
    wait_idle();
    rd_lat = 1;

    // R8: command presented while busy is ignored
    send(1, 26'd5, 0);
    host_word  = {1'b0, 26'd5, 5'd0, 32'hBAD0_BAD0};
    host_valid = 1'b1;
    @(negedge clk);
    host_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(cnt_cmd == exp_cmds, "R8 no extra command", cnt_cmd, exp_cmds);
    send(1, 26'd5, 0);

    wait_idle();
    repeat (15) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all reads returned", sb_q.size(), 0);
    chk(cnt_rd == cnt_cmd - cnt_wr, "R7 one pop per read", cnt_rd, cnt_cmd - cnt_wr);
    chk(cnt_cmd == exp_cmds, "R10 command count", cnt_cmd, exp_cmds);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule